// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block provides three independent down-counting timer channels behind a small byte-wide host port. A host writes a 16-bit start value into a channel as two bytes and picks its operating style through a shared control-word address. Each channel then counts down once per pulse of a shared single-cycle `tick` enable, which is taken from a slow fixed timer clock of roughly 1.19 MHz. On expiry it raises a one-cycle interrupt pulse and updates its output level.

Three styles are available. One-shot mode expires once and holds its level high. Rate mode reloads itself and fires periodically. Square mode does the same and also flips its level on every expiry. The host reads a live count as two bytes. It may also freeze a count with a latch command, either for one channel or for a chosen group of channels at once, so that a two-byte read stays coherent while the channel keeps counting.

Top module: `pit_timer3`

## Requirements
- R1: A channel is loaded by two data writes to its address, low byte first and then high byte. A single write pointer per channel alternates between the two, and counting begins only after the high byte.
- R2: Writing the low byte stops the channel and drives its output level to 0. A stopped channel never fires and reports a count of 0.
- R3: One-shot mode (mode field 0): a load of N fires once, exactly N ticks after the high byte. On that tick the level goes to 1 and stays there, and the channel stops and reports 0.
- R4: Rate mode (mode field 2): a load of N (N >= 2) fires every N-1 ticks and reloads automatically. Its level stays 0.
- R5: Square mode (mode field 3): the period is the same as in rate mode. The output level inverts at every expiry, starting from 0.
- R6: The count reported to the host is the remaining ticks to expiry in one-shot mode, the remaining ticks plus 1 in the two periodic modes, and 0 when stopped. Right after a load in any mode it therefore equals the loaded value.
- R7: Each expiry raises that channel's `irq` bit for exactly one clock cycle, the cycle after the expiring tick.
- R8: A control word with select field bits 7:6 equal to 0..2 and access field bits 5:4 equal to 0 latches that channel's reported count. Reads then return the held value, low byte then high byte, and reading the high byte releases the hold. A further latch command while the hold is pending is ignored.
- R9: A control word with select field 3 is a group latch. When bit 5 is 0, it latches every channel n whose bit n+1 is set. When bit 5 is 1, it latches nothing.
- R10: A control word with select field 0..2 programs that channel's mode (bits 3:1) only when the access field is 3, bit 0 (decimal counting) is 0 and the mode is 0, 2 or 3. Any other such word leaves the channel's mode unchanged.
- R11: A load whose period works out to 0 does not start the channel. That is a value of 0 in one-shot mode, or 1 in the periodic modes.
- R12: With no latch pending, reads of a channel address return the live reported count, low byte then high byte, through a per-channel read pointer. A read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Single-cycle count enable shared by all channels |
| addr | input | 2 | 0..2 select a channel's data port, 3 selects the control word |
| wr | input | 1 | Write strobe for `wdata` at `addr` |
| rd | input | 1 | Read strobe; advances the addressed channel's read pointer |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte for `addr`, valid in the cycle `rd` is high |
| out_lvl | output | 3 | Output level of each channel |
| irq | output | 3 | One-cycle expiry pulse of each channel |

## Verification
A wrong down-counter or reload value shows up as a reported count that is off on the very next read. It also shows up as an `irq` pulse that lands a tick early or late, which becomes visible within one period. A stuck byte pointer swaps the two halves of a value on the next two-byte read or load. A hold flag that is not cleared or not set makes a second read return a stale or a moving value. A wrong level register shows on `out_lvl` in the cycle after the expiry or the low-byte write.

// File: rtl/pit_pkg.sv
package pit_pkg;

    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;

    typedef enum logic [2:0] {
        MODE_ONESHOT = 3'd0,
        MODE_RATE    = 3'd2,
        MODE_SQUARE  = 3'd3
    } pit_mode_e;

    typedef struct packed {
        logic [COUNT_W-1:0] cnt;      // ticks left to expiry
        logic [COUNT_W-1:0] period;   // reload value
        logic [COUNT_W-1:0] load;     // value assembled from host bytes
        logic [COUNT_W-1:0] held;     // frozen count
        pit_mode_e          mode;
        logic               run;
        logic               lvl;
        logic               wptr;     // 0: next write is low byte
        logic               rptr;     // 0: next read is low byte
        logic               held_on;
        logic               irq;
    } chan_state_t;

    function automatic logic is_periodic(input pit_mode_e m);
        return (m == MODE_RATE) || (m == MODE_SQUARE);
    endfunction

    function automatic logic mode_ok(input logic [2:0] m);
        return (m == 3'd0) || (m == 3'd2) || (m == 3'd3);
    endfunction

endpackage

// File: rtl/pit_ctrl_decode.sv
module pit_ctrl_decode
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] rd_en,
    output logic [NUM_CH-1:0] prog_en,
    output logic [NUM_CH-1:0] latch_en,
    output pit_mode_e         prog_mode
);

    localparam logic [1:0] CTRL_ADDR  = 2'd3;
    localparam logic [1:0] SEL_GROUP  = 2'd3;
    localparam logic [1:0] ACC_LATCH  = 2'd0;
    localparam logic [1:0] ACC_WORD16 = 2'd3;

    logic [1:0] sel;
    logic [1:0] acc;
    logic [2:0] md;
    logic       dec;
    logic       ctrl_wr;

    assign sel       = wdata[7:6];
    assign acc       = wdata[5:4];
    assign md        = wdata[3:1];
    assign dec       = wdata[0];
    assign ctrl_wr   = wr && (addr == CTRL_ADDR);
    assign prog_mode = pit_mode_e'(md);

    always_comb begin
        data_we  = '0;
        rd_en    = '0;
        prog_en  = '0;
        latch_en = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            data_we[i] = wr && (addr == 2'(i));
            rd_en[i]   = rd && (addr == 2'(i));
            if (ctrl_wr) begin
                if (sel == SEL_GROUP) begin
                    // group latch: count bit is active low, one select bit per channel
                    latch_en[i] = !wdata[5] && wdata[i+1];
                end else if (sel == 2'(i)) begin
                    if (acc == ACC_LATCH) begin
                        latch_en[i] = 1'b1;
                    end else if (acc == ACC_WORD16 && !dec && mode_ok(md)) begin
                        prog_en[i] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              data_we,
    input  logic [BYTE_W-1:0] data_in,
    input  logic              rd_en,
    input  logic              prog_en,
    input  pit_mode_e         prog_mode,
    input  logic              latch_en,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              lvl,
    output logic              irq
);

    chan_state_t s_d, s_q;

    logic [COUNT_W-1:0] live_cnt;
    logic [COUNT_W-1:0] shown_cnt;
    logic [COUNT_W-1:0] new_load;
    logic [COUNT_W-1:0] new_period;

    always_comb begin
        if (!s_q.run)                 live_cnt = '0;
        else if (is_periodic(s_q.mode)) live_cnt = s_q.cnt + 1'b1;
        else                          live_cnt = s_q.cnt;
    end

    assign shown_cnt  = s_q.held_on ? s_q.held : live_cnt;
    assign rd_byte    = s_q.rptr ? shown_cnt[COUNT_W-1:BYTE_W] : shown_cnt[BYTE_W-1:0];
    assign new_load   = {data_in, s_q.load[BYTE_W-1:0]};
    assign new_period = is_periodic(s_q.mode) ? new_load - 1'b1 : new_load;

    always_comb begin
        s_d     = s_q;
        s_d.irq = 1'b0;

        // counting
        if (tick && s_q.run) begin
            if (s_q.cnt == 1) begin
                s_d.irq = 1'b1;
                unique case (s_q.mode)
                    MODE_RATE:   s_d.cnt = s_q.period;
                    MODE_SQUARE: begin
                        s_d.cnt = s_q.period;
                        s_d.lvl = ~s_q.lvl;
                    end
                    default: begin
                        s_d.cnt = '0;
                        s_d.run = 1'b0;
                        s_d.lvl = 1'b1;
                    end
                endcase
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end

        // count hold
        if (latch_en && !s_q.held_on) begin
            s_d.held_on = 1'b1;
            s_d.rptr    = 1'b0;
            s_d.held    = live_cnt;
        end

        // host read
        if (rd_en) begin
            s_d.rptr = ~s_q.rptr;
            if (s_q.held_on && s_q.rptr) s_d.held_on = 1'b0;
        end

        // host data write
        if (data_we) begin
            if (!s_q.wptr) begin
                s_d.load[BYTE_W-1:0] = data_in;
                s_d.run              = 1'b0;
                s_d.lvl              = 1'b0;
                s_d.cnt              = '0;
                s_d.wptr             = 1'b1;
            end else begin
                s_d.load   = new_load;
                s_d.period = new_period;
                s_d.cnt    = new_period;
                s_d.run    = (new_period != '0);
                s_d.wptr   = 1'b0;
            end
        end

        if (prog_en) s_d.mode = prog_mode;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MODE_ONESHOT;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl = s_q.lvl;
    assign irq = s_q.irq;

    // R2: a low-byte write leaves the channel stopped with its level low
    a_r2_low_write_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (data_we && !s_q.wptr) |=> (!s_q.run && !s_q.lvl));

    // R3: once a one-shot channel has expired, its level holds until reloaded
    a_r3_oneshot_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.lvl && s_q.mode == MODE_ONESHOT && !data_we && !prog_en) |=> s_q.lvl);

    // R7: an interrupt pulse follows a tick seen by a running channel
    a_r7_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |-> ($past(tick) && $past(s_q.run)));

    // R11: a running channel never holds a zero or out-of-range count
    a_r11_running_count_valid: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.cnt != '0 && s_q.cnt <= s_q.period));

    // R8: the held value does not move while a hold is pending
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.held_on |=> $stable(s_q.held));

endmodule

// File: rtl/pit_timer3.sv
module pit_timer3
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CH-1:0] out_lvl,
    output logic [NUM_CH-1:0] irq
);

    logic [NUM_CH-1:0] data_we;
    logic [NUM_CH-1:0] rd_en;
    logic [NUM_CH-1:0] prog_en;
    logic [NUM_CH-1:0] latch_en;
    pit_mode_e         prog_mode;
    logic [BYTE_W-1:0] rd_byte [NUM_CH];

    pit_ctrl_decode #(.NUM_CH(NUM_CH)) u_dec (
        .wr       (wr),
        .rd       (rd),
        .addr     (addr),
        .wdata    (wdata),
        .data_we  (data_we),
        .rd_en    (rd_en),
        .prog_en  (prog_en),
        .latch_en (latch_en),
        .prog_mode(prog_mode)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pit_channel u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .data_we  (data_we[g]),
            .data_in  (wdata),
            .rd_en    (rd_en[g]),
            .prog_en  (prog_en[g]),
            .prog_mode(prog_mode),
            .latch_en (latch_en[g]),
            .rd_byte  (rd_byte[g]),
            .lvl      (out_lvl[g]),
            .irq      (irq[g])
        );
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (addr == 2'(i)) rdata = rd_byte[i];
        end
    end

    // R12: the control address never returns data
    a_r12_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 2'd3) |-> (rdata == '0));

    // R7: interrupt pulses only appear after a tick cycle
    a_r7_irq_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (irq != '0) |-> $past(tick));

endmodule

// File: tb/pit_timer3_bench.sv
module pit_timer3_bench;

    localparam time CLK_HALF = 2.5ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] out_lvl;
    logic [2:0] irq;

    int n_chk = 0;
    int n_err = 0;
    int fires [3];
    bit done = 1'b0;

    always #CLK_HALF clk = ~clk;

    pit_timer3 u_pit_timer3 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .out_lvl(out_lvl), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    task automatic write_byte(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic read_byte(input logic [1:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        #1 v = rdata;
        @(posedge clk); #1;
        rd = 1'b0;
    endtask

    task automatic read16(input int ch, output int v);
        logic [7:0] lo, hi;
        read_byte(2'(ch), lo);
        read_byte(2'(ch), hi);
        v = {hi, lo};
    endtask

    task automatic load(input int ch, input int val);
        write_byte(2'(ch), val[7:0]);
        write_byte(2'(ch), val[15:8]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
            for (int c = 0; c < 3; c++) fires[c] += int'(irq[c]);
        end
    endtask

    function automatic int per_reported(input int n, input int k);
        return n - (k % (n - 1));
    endfunction

    function automatic int per_fires(input int n, input int k);
        return k / (n - 1);
    endfunction

    function automatic logic [7:0] ctrl_word(input int sel, input int acc, input int md, input int bcd);
        return {2'(sel), 2'(acc), 3'(md), 1'(bcd)};
    endfunction

    initial begin
        #(CLK_HALF * 2 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        int v, n, k;
        logic [7:0] b;
        void'($urandom(32'd1234));
        for (int c = 0; c < 3; c++) fires[c] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // reset state
        chk("R2 reset level", int'(out_lvl), 0);
        chk("R7 reset irq", int'(irq), 0);
        for (int c = 0; c < 3; c++) begin
            read16(c, v);
            chk("R6 reset count", v, 0);
        end
        read_byte(2'd3, b);
        chk("R12 control address read", int'(b), 0);

        // one-shot on channel 0
        write_byte(2'd3, ctrl_word(0, 3, 0, 0));
        write_byte(2'd0, 8'd10);
        ticks(3);
        read16(0, v);
        chk("R1 no count before high byte", v, 0);
        write_byte(2'd0, 8'd0);
        read16(0, v);
        chk("R1 count after load", v, 10);
        fires[0] = 0;
        ticks(4);
        read16(0, v);
        chk("R6 one-shot remaining", v, 6);
        ticks(6);
        chk("R3 one-shot fired once", fires[0], 1);
        chk("R3 one-shot level high", int'(out_lvl[0]), 1);
        read16(0, v);
        chk("R3 one-shot stopped count", v, 0);
        ticks(25);
        chk("R3 no refire", fires[0], 1);
        chk("R3 level stays high", int'(out_lvl[0]), 1);

        // rate mode, random loads and tick counts, channel 1
        write_byte(2'd3, ctrl_word(1, 3, 2, 0));
        for (int it = 0; it < 8; it++) begin
            n = 2 + int'($urandom_range(0, 60));
            k = int'($urandom_range(0, 200));
            load(1, n);
            fires[1] = 0;
            ticks(k);
            read16(1, v);
            chk("R4 rate reported count", v, per_reported(n, k));
            chk("R4 rate fire count", fires[1], per_fires(n, k));
            chk("R4 rate level low", int'(out_lvl[1]), 0);
        end

        // square mode, random, channel 2
        write_byte(2'd3, ctrl_word(2, 3, 3, 0));
        for (int it = 0; it < 8; it++) begin
            n = 2 + int'($urandom_range(0, 40));
            k = int'($urandom_range(0, 200));
            load(2, n);
            fires[2] = 0;
            ticks(k);
            read16(2, v);
            chk("R5 square reported count", v, per_reported(n, k));
            chk("R5 square fire count", fires[2], per_fires(n, k));
            chk("R5 square level", int'(out_lvl[2]), per_fires(n, k) % 2);
        end

        // R2: low-byte write mid-run stops the channel and clears its level
        load(2, 5);
        ticks(4);
        chk("R5 square level after one expiry", int'(out_lvl[2]), 1);
        write_byte(2'd2, 8'd7);
        chk("R2 level cleared by low byte", int'(out_lvl[2]), 0);
        fires[2] = 0;
        ticks(12);
        read16(2, v);
        chk("R2 stopped count", v, 0);
        chk("R2 stopped no fire", fires[2], 0);
        write_byte(2'd2, 8'd0);
        read16(2, v);
        chk("R1 low byte kept across stop", v, 7);

        // R7: interrupt pulse width, period of one tick
        load(1, 2);
        tick = 1'b1;
        @(posedge clk); #1;
        tick = 1'b0;
        chk("R7 irq high after expiring tick", int'(irq[1]), 1);
        @(posedge clk); #1;
        chk("R7 irq one cycle only", int'(irq[1]), 0);

        // R8: single-channel hold
        load(1, 1000);
        ticks(5);
        write_byte(2'd3, ctrl_word(1, 0, 0, 0));
        ticks(7);
        read_byte(2'd1, b);
        chk("R8 held low byte", int'(b), 995 & 8'hFF);
        write_byte(2'd3, ctrl_word(1, 0, 0, 0));
        ticks(1);
        read_byte(2'd1, b);
        chk("R8 held high byte, relatch ignored", int'(b), 995 >> 8);
        read16(1, v);
        chk("R12 live count after release", v, 1000 - 13);

        // R9: group latch of channels 0 and 2
        write_byte(2'd3, ctrl_word(0, 3, 0, 0));
        load(0, 500);
        load(2, 300);
        load(1, 1000);
        ticks(10);
        write_byte(2'd3, 8'b1101_1010);
        ticks(20);
        read16(0, v);
        chk("R9 channel 0 held", v, 490);
        read16(2, v);
        chk("R9 channel 2 held", v, 290);
        read16(1, v);
        chk("R9 channel 1 not held", v, 970);
        write_byte(2'd3, 8'b1111_1110);
        ticks(5);
        read16(0, v);
        chk("R9 count bit high latches nothing", v, 465);

        // R10: rejected control words leave channel 1 in rate mode
        write_byte(2'd3, ctrl_word(1, 3, 1, 0));
        write_byte(2'd3, ctrl_word(1, 3, 0, 1));
        write_byte(2'd3, ctrl_word(1, 1, 0, 0));
        load(1, 20);
        fires[1] = 0;
        ticks(19);
        chk("R10 mode kept, fires", fires[1], 1);
        read16(1, v);
        chk("R10 mode kept, reload", v, 20);

        // R11: zero periods do not start
        load(0, 0);
        read16(0, v);
        chk("R11 one-shot load 0 count", v, 0);
        fires[0] = 0;
        ticks(5);
        chk("R11 one-shot load 0 no fire", fires[0], 0);
        chk("R11 one-shot load 0 level", int'(out_lvl[0]), 0);
        load(1, 1);
        read16(1, v);
        chk("R11 rate load 1 count", v, 0);
        fires[1] = 0;
        ticks(5);
        chk("R11 rate load 1 no fire", fires[1], 0);

        summary();
    end

endmodule